// File: doc/BRIEF.md
# Operand Ordering and Carry Flag Stage

This block produces the comparison and carry flags for one processing-element ALU. Two operands of a parameterized width enter together with a mode bit that selects a two's-complement or an unsigned reading. The block forms the width-truncated difference of the two operands and their full-width sum. It derives the ordering flags from the most significant bits only: one from each operand and one from the difference. An equality detector completes the flag set. The sum supplies a carry that is placed in a 4-bit flag nibble.

No magnitude comparator is used. When the operand sign bits agree, the difference cannot overflow, so its top bit gives the order. When they disagree, the operand bits settle the order on their own. The two modes read that disagreement in opposite directions. All outputs are registered. A result appears one clock after its operands are presented, and a synchronous active-high reset clears it.

Top module: `cmpflag_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is zero after that edge.
- R2: `eq_o` is high exactly when `op_a` equals `op_b`, in either mode.
- R3: With `is_signed` high, `ge_o` is high exactly when `op_a` is greater than or equal to `op_b` as two's-complement numbers.
- R4: With `is_signed` high, `le_o` is high exactly when `op_a` is less than or equal to `op_b` as two's-complement numbers.
- R5: With `is_signed` low, `ge_o` is high exactly when `op_a` is greater than or equal to `op_b` as unsigned numbers.
- R6: With `is_signed` low, `le_o` is high exactly when `op_a` is less than or equal to `op_b` as unsigned numbers.
- R7: Bit 3 of `flags_o` is high exactly when the unsigned sum `op_a + op_b` is at least 2 to the power `W`. This holds in either mode.
- R8: Bits 2, 1 and 0 of `flags_o` are always zero.
- R9: Each output reflects the operands and mode sampled at the previous rising clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| is_signed | input | 1 | 1 = two's-complement ordering, 0 = unsigned ordering |
| ge_o | output | 1 | op_a greater than or equal to op_b |
| eq_o | output | 1 | op_a equal to op_b |
| le_o | output | 1 | op_a less than or equal to op_b |
| flags_o | output | 4 | Flag nibble, carry in bit 3, other bits zero |

## Verification
The assertions rely on the operands and mode being known values, never X or Z, at every rising edge after reset. Under that condition the flags always form a total order: at least one of greater-or-equal and less-or-equal is high, and both are high only when the operands are equal. The stimulus changes inputs only on falling edges and always drives full-width defined values. The values include the sign-boundary pairs, the equal pairs and the wrap-around sums in both modes, followed by pseudo-random pairs.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;
  localparam int FLAG_W    = 4;
  localparam int CARRY_POS = 3;

  typedef struct packed {
    logic ge;
    logic eq;
    logic le;
  } order_t;
endpackage

// File: rtl/cmpflag_eq.sv
module cmpflag_eq #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         same
);
  logic [W-1:0] bit_match;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign bit_match[gi] = ~(a[gi] ^ b[gi]);
    end
  endgenerate

  assign same = &bit_match;
endmodule

// File: rtl/cmpflag_arith.sv
module cmpflag_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         diff_msb,
  output logic         carry
);
  localparam int SW = W + 1;

  logic [W-1:0]  diff;
  logic [SW-1:0] sum_ext;

  // difference is truncated to W bits; only its sign position is used
  assign diff     = a - b;
  assign diff_msb = diff[W-1];

  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign carry   = sum_ext[SW-1];
endmodule

// File: rtl/cmpflag_order.sv
module cmpflag_order
  import cmpflag_pkg::*;
(
  input  logic   a_msb,
  input  logic   b_msb,
  input  logic   d_msb,
  input  logic   same,
  input  logic   is_signed,
  output order_t ord
);
  logic msb_agree;
  logic a_hi_b_lo;
  logic a_lo_b_hi;
  logic a_above;
  logic a_below;

  assign msb_agree = ~(a_msb ^ b_msb);
  assign a_hi_b_lo = a_msb & ~b_msb;
  assign a_lo_b_hi = ~a_msb & b_msb;

  // a sign mismatch means the opposite thing in the two readings
  always_comb begin
    if (is_signed) begin
      a_above = a_lo_b_hi;
      a_below = a_hi_b_lo;
    end else begin
      a_above = a_hi_b_lo;
      a_below = a_lo_b_hi;
    end
    ord.ge = (msb_agree & ~d_msb) | a_above;
    ord.le = (msb_agree &  d_msb) | a_below | same;
    ord.eq = same;
  end
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
  import cmpflag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic              is_signed,
  output logic              ge_o,
  output logic              eq_o,
  output logic              le_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int TOP = W - 1;

  logic              same;
  logic              d_msb;
  logic              carry;
  order_t            ord;
  logic [FLAG_W-1:0] flags_next;

  cmpflag_eq #(.W(W)) u_eq (
    .a    (op_a),
    .b    (op_b),
    .same (same)
  );

  cmpflag_arith #(.W(W)) u_arith (
    .a        (op_a),
    .b        (op_b),
    .diff_msb (d_msb),
    .carry    (carry)
  );

  cmpflag_order u_order (
    .a_msb     (op_a[TOP]),
    .b_msb     (op_b[TOP]),
    .d_msb     (d_msb),
    .same      (same),
    .is_signed (is_signed),
    .ord       (ord)
  );

  genvar fi;
  generate
    for (fi = 0; fi < FLAG_W; fi++) begin : g_flag
      if (fi == CARRY_POS) begin : g_carry
        assign flags_next[fi] = carry;
      end else begin : g_zero
        assign flags_next[fi] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ge_o    <= 1'b0;
      eq_o    <= 1'b0;
      le_o    <= 1'b0;
      flags_o <= '0;
    end else begin
      ge_o    <= ord.ge;
      eq_o    <= ord.eq;
      le_o    <= ord.le;
      flags_o <= flags_next;
    end
  end
endmodule

// File: rtl/cmpflag_unit_chk.sv
module cmpflag_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         is_signed,
  input logic         ge_o,
  input logic         eq_o,
  input logic         le_o,
  input logic [3:0]   flags_o
);
  logic [W-1:0] wrapped;
  logic         live;

  assign wrapped = op_a + op_b;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assert_total_order_R3: assert property (@(posedge clk) disable iff (rst)
    live |-> (ge_o || le_o));

  assert_both_means_equal_R4: assert property (@(posedge clk) disable iff (rst)
    (ge_o && le_o) |-> eq_o);

  assert_equal_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (eq_o == ($past(op_a) == $past(op_b))));

  assert_carry_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_o[3] == ($past(wrapped) < $past(op_a))));

  assert_low_bits_zero_R8: assert property (@(posedge clk) disable iff (rst)
    flags_o[2:0] == 3'b000);

  assert_unsigned_top_R5: assert property (@(posedge clk) disable iff (rst)
    (!is_signed && op_a[W-1] && !op_b[W-1]) |=> (ge_o && !le_o));
endmodule

bind cmpflag_unit cmpflag_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_a      (op_a),
  .op_b      (op_b),
  .is_signed (is_signed),
  .ge_o      (ge_o),
  .eq_o      (eq_o),
  .le_o      (le_o),
  .flags_o   (flags_o)
);

// File: tb/test_cmpflag_unit.sv
module test_cmpflag_unit;
  localparam int W          = 16;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 400;

  typedef struct {
    logic       ge;
    logic       eq;
    logic       le;
    logic [3:0] flags;
    logic       sm;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '1;
  logic [W-1:0] op_b = 16'h0001;
  logic         is_signed = 1'b0;
  logic         ge_o, eq_o, le_o;
  logic [3:0]   flags_o;

  int   total = 0;
  int   fails = 0;
  bit   done  = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpflag_unit #(.W(W)) i_cmpflag_unit (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .is_signed(is_signed),
    .ge_o(ge_o), .eq_o(eq_o), .le_o(le_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: present operands, then push the expected result once captured
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic sm);
    exp_t e;
    logic [W:0] s;
    @(negedge clk);
    op_a = a; op_b = b; is_signed = sm;
    s = {1'b0, a} + {1'b0, b};
    e.eq = (a == b);
    e.ge = sm ? ($signed(a) >= $signed(b)) : (a >= b);
    e.le = sm ? ($signed(a) <= $signed(b)) : (a <= b);
    e.flags = {s[W], 3'b000};
    e.sm = sm;
    @(posedge clk);
    sb_q.push_back(e);
  endtask

  // monitor: one cycle after capture (R9), compare each field
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R2 R9 eq", {3'b0, eq_o}, {3'b0, e.eq});
        if (e.sm) begin
          chk("R3 signed ge", {3'b0, ge_o}, {3'b0, e.ge});
          chk("R4 signed le", {3'b0, le_o}, {3'b0, e.le});
        end else begin
          chk("R5 unsigned ge", {3'b0, ge_o}, {3'b0, e.ge});
          chk("R6 unsigned le", {3'b0, le_o}, {3'b0, e.le});
        end
        chk("R7 carry bit3", {3'b0, flags_o[3]}, {3'b0, e.flags[3]});
        chk("R8 low flag bits", {1'b0, flags_o[2:0]}, 4'h0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {ge_o, eq_o, le_o, 1'b0} | flags_o, 4'h0);
    rst = 1'b0;

    for (int m = 0; m < 2; m++) begin
      apply(16'h0000, 16'h0000, m[0]);
      apply(16'h7FFF, 16'h8000, m[0]);
      apply(16'h8000, 16'h7FFF, m[0]);
      apply(16'hFFFF, 16'h0001, m[0]);
      apply(16'h0001, 16'hFFFF, m[0]);
      apply(16'h8000, 16'h8000, m[0]);
      apply(16'hFFFF, 16'hFFFF, m[0]);
      apply(16'h1234, 16'h1235, m[0]);
      apply(16'hFFFF, 16'h0000, m[0]);
      apply(16'h8001, 16'h8000, m[0]);
    end
    for (int i = 0; i < N_RAND; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (i % 7 == 0) ? ra : W'($urandom);
      apply(ra, rb, i[0]);
    end
    @(negedge clk);
    @(negedge clk);

    // reset in mid-run with operands that would set carry and eq
    op_a = 16'hC000; op_b = 16'hC000; is_signed = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid-run reset", {ge_o, eq_o, le_o, 1'b0} | flags_o, 4'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule